// File: doc/BRIEF.md
# Edge-Triggered Wake-Up and Interrupt Combiner

This block watches a set of asynchronous input lines (sixteen by default) and records an edge on each of them as a pending flag. Software picks which lines take part and whether each line reacts to a rising or a falling transition. The flags are then combined into a small group of maskable interrupt request lines (four by default) and one wake-up line. A power-mode controller uses the wake-up line to leave halt, idle or power-save operation.

Each line goes through a two-flop synchroniser and an edge register. A single physical transition therefore sets its flag exactly once, however long the new level is held. Each line has its own 2-bit routing field that selects the interrupt output it feeds. Software clears a flag by writing a one to its bit. The wake-up line ignores routing: it rises for any flag that is pending on an enabled line.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset the enable, polarity, routing and pending registers all read 0, `irq` is 0 and `wake` is 0.
- R2: When `pol` bit c is 0 and `en` bit c is 1, a rising transition on `ch_in[c]` sets pending bit c. A change of `ch_in` that is applied between clock edges becomes visible at the third rising clock edge that follows, and not before.
- R3: When `pol` bit c is 1, a falling transition sets pending bit c. A transition in the other direction leaves the bit unchanged.
- R4: When `en` bit c is 0, transitions on `ch_in[c]` never set pending bit c.
- R5: One level change sets its pending bit only once. After the bit is cleared, it stays clear for as long as the input holds the new level.
- R6: `irq[k]` is the OR, over all channels c, of pending and enabled bit c whose routing field equals k. Channel c's 2-bit field lies in the routing register at address 4 + c/8, in bits 2*(c%8)+1 down to 2*(c%8). A change to a routing field takes effect on `irq` without any new edge.
- R7: A write to address 2 clears each pending bit whose `wdata` bit is 1. Pending bits whose `wdata` bit is 0 keep their value.
- R8: If an edge sets a pending bit in the same cycle as a write that clears that bit, the bit ends up set. Other bits named in the same write are still cleared.
- R9: `wake` is 1 exactly when at least one enabled channel has its pending bit set, whatever its routing.
- R10: Clearing a channel's enable bit keeps its pending bit set while dropping its share of `irq` and `wake`. Setting the enable bit again restores both.
- R11: Register map, all 16 bits wide and read back on `rdata` combinationally: address 0 is enable, address 1 is polarity (1 = falling), address 2 is pending, addresses 4 and 5 are routing. Addresses 3, 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_in | input | 16 | Asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| irq | output | 4 | Combined interrupt request lines |
| wake | output | 1 | Wake-up request to the power-mode controller |

## Verification
The hardest case to reach from the ports is R8: an edge detection and a clear write landing on the same clock edge. The detection cycle is set by the synchroniser depth and is not visible at the ports. The stimulus changes an input line half a cycle before a clock edge. It counts two edges, then raises the clear strobe so that it is sampled on the third edge, the one that also latches the edge. The same write names a second, older pending bit, which shows that the clear still acts on bits that have no edge in that cycle.

// File: rtl/ewu_pkg.sv
package ewu_pkg;
   // register addresses; routing registers occupy ADDR_ROUTE0 upward
   localparam int ADDR_EN     = 0;
   localparam int ADDR_POL    = 1;
   localparam int ADDR_PEND   = 2;
   localparam int ADDR_ROUTE0 = 4;
endpackage

// File: rtl/ewu_sync.sv
module ewu_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ewu_regs.sv
module ewu_regs
   import ewu_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int SEL_W  = 2,
   parameter int ADDR_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [NUM_CH-1:0]       wdata,
   input  logic [NUM_CH-1:0]       pend,
   output logic [NUM_CH-1:0]       en,
   output logic [NUM_CH-1:0]       pol,
   output logic [NUM_CH*SEL_W-1:0] route,
   output logic [NUM_CH-1:0]       clr,
   output logic [NUM_CH-1:0]       rdata
);
   localparam int ROUTE_REGS = SEL_W;

   logic [ROUTE_REGS-1:0][NUM_CH-1:0] route_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= '0;
         pol     <= '0;
         route_q <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_W'(ADDR_EN))  en  <= wdata;
         if (addr == ADDR_W'(ADDR_POL)) pol <= wdata;
         for (int r = 0; r < ROUTE_REGS; r++) begin
            if (addr == ADDR_W'(ADDR_ROUTE0 + r)) route_q[r] <= wdata;
         end
      end
   end

   assign route = route_q;
   assign clr   = (wr_en && addr == ADDR_W'(ADDR_PEND)) ? wdata : '0;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_EN))   rdata = en;
      if (addr == ADDR_W'(ADDR_POL))  rdata = pol;
      if (addr == ADDR_W'(ADDR_PEND)) rdata = pend;
      for (int r = 0; r < ROUTE_REGS; r++) begin
         if (addr == ADDR_W'(ADDR_ROUTE0 + r)) rdata = route_q[r];
      end
   end
endmodule

// File: rtl/ewu_pending.sv
module ewu_pending #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] sync_in,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] pol,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] pend
);
   logic [NUM_CH-1:0] prev_q;
   logic [NUM_CH-1:0] hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rise, fall;
      assign rise   = sync_in[c] & ~prev_q[c];
      assign fall   = ~sync_in[c] & prev_q[c];
      assign hit[c] = en[c] & (pol[c] ? fall : rise);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend   <= '0;
      end else begin
         prev_q <= sync_in;
         pend   <= (pend & ~clr) | hit;   // a new edge outranks a clear
      end
   end
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
   import ewu_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int NUM_IRQ     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  ch_in,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_CH-1:0]  wdata,
   output logic [NUM_CH-1:0]  rdata,
   output logic [NUM_IRQ-1:0] irq,
   output logic               wake
);
   localparam int SEL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if (NUM_IRQ < 2 || (NUM_IRQ & (NUM_IRQ - 1)) != 0) begin : g_bad_irq
      $error("NUM_IRQ must be a power of two, at least 2");
   end
   if (NUM_CH % SEL_W != 0) begin : g_bad_ch
      $error("NUM_CH must be a multiple of the routing field width");
   end
   if (ADDR_ROUTE0 + SEL_W > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the routing registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_CH-1:0]       sync_q;
   logic [NUM_CH-1:0]       en_q, pol_q, clr_mask, pend_q;
   logic [NUM_CH*SEL_W-1:0] route_flat;

   ewu_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(ch_in), .q(sync_q));

   ewu_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .pend(pend_q), .en(en_q), .pol(pol_q), .route(route_flat),
      .clr(clr_mask), .rdata(rdata));

   ewu_pending #(.NUM_CH(NUM_CH)) pend_i (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .en(en_q), .pol(pol_q),
      .clr(clr_mask), .pend(pend_q));

   logic [NUM_CH-1:0] live;
   assign live = pend_q & en_q;

   for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      always_comb begin
         irq[k] = 1'b0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (route_flat[c*SEL_W +: SEL_W] == SEL_W'(k)) irq[k] = irq[k] | live[c];
         end
      end
   end

   assign wake = |live;
endmodule

// File: rtl/ewu_chk.sv
module ewu_chk #(
   parameter int NUM_CH    = 16,
   parameter int NUM_IRQ   = 4,
   parameter int ADDR_W    = 3,
   parameter int PEND_ADDR = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [NUM_CH-1:0]  wdata,
   input logic [NUM_CH-1:0]  pend,
   input logic [NUM_CH-1:0]  en,
   input logic [NUM_IRQ-1:0] irq,
   input logic               wake
);
   logic [NUM_CH-1:0] clr_req;
   always_comb clr_req = (wr_en && addr == ADDR_W'(PEND_ADDR)) ? wdata : '0;

   // R4
   new_set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(en)) == '0);

   // R7
   pend_kept_unless_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend) & ~pend & ~$past(clr_req)) == '0);

   // R9
   irq_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |-> wake);

   // R9
   no_pending_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (!wake && irq == '0));

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> (!wake && irq == '0));
endmodule

bind edge_wake_ctrl ewu_chk #(
   .NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .PEND_ADDR(ewu_pkg::ADDR_PEND)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .pend(pend_q), .en(en_q), .irq(irq), .wake(wake));

// File: tb/edge_wake_ctrl_tb.sv
module edge_wake_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ch_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  irq;
   logic        wake;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   edge_wake_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake));

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   // input change at a falling edge, pending visible after third rising edge
   task automatic drive(logic [15:0] v);
      @(negedge clk); ch_in = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic tidy();
      wr(3'd0, 16'h0000);
      drive(16'h0000);
      wr(3'd2, 16'hFFFF);
      wr(3'd1, 16'h0000);
      wr(3'd4, 16'h0000);
      wr(3'd5, 16'h0000);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); check("R1 reset register read", v, 16'h0);
      end
      check("R1 reset irq", {12'h0, irq}, 16'h0);
      check("R1 reset wake", {15'h0, wake}, 16'h0);
   endtask

   task automatic t_regmap();
      logic [15:0] v;
      wr(3'd0, 16'hA5A5); wr(3'd1, 16'h3C3C); wr(3'd4, 16'h1234); wr(3'd5, 16'hFEDC);
      wr(3'd3, 16'hFFFF); wr(3'd7, 16'hFFFF);
      rd(3'd0, v); check("R11 enable readback", v, 16'hA5A5);
      rd(3'd1, v); check("R11 polarity readback", v, 16'h3C3C);
      rd(3'd4, v); check("R11 route0 readback", v, 16'h1234);
      rd(3'd5, v); check("R11 route1 readback", v, 16'hFEDC);
      rd(3'd3, v); check("R11 unused address 3", v, 16'h0);
      rd(3'd7, v); check("R11 unused address 7", v, 16'h0);
      rd(3'd2, v); check("R11 pending untouched by config", v, 16'h0);
      tidy();
   endtask

   task automatic t_rise();
      logic [15:0] v;
      wr(3'd0, 16'h0001);
      @(negedge clk); ch_in = 16'h0001;
      repeat (2) @(posedge clk); @(negedge clk);
      check("R2 not yet after two edges", {15'h0, wake}, 16'h0);
      @(posedge clk); @(negedge clk);
      rd(3'd2, v); check("R2 rising sets pending", v, 16'h0001);
      check("R2 irq0", {12'h0, irq}, 16'h1);
      wr(3'd2, 16'h0001);
      rd(3'd2, v); check("R7 write one clears", v, 16'h0);
      repeat (5) @(negedge clk);
      rd(3'd2, v); check("R5 held level does not re-set", v, 16'h0);
      drive(16'h0000);
      rd(3'd2, v); check("R2 falling ignored with pol 0", v, 16'h0);
      drive(16'h0001);
      wr(3'd2, 16'hFFFE);
      rd(3'd2, v); check("R7 write zero keeps bit", v, 16'h0001);
      tidy();
   endtask

   task automatic t_fall();
      logic [15:0] v;
      wr(3'd1, 16'h0002); wr(3'd0, 16'h0002);
      drive(16'h0002);
      rd(3'd2, v); check("R3 rising ignored with pol 1", v, 16'h0);
      drive(16'h0000);
      rd(3'd2, v); check("R3 falling sets pending", v, 16'h0002);
      tidy();
   endtask

   task automatic t_disabled();
      logic [15:0] v;
      drive(16'h0004); drive(16'h0000);
      rd(3'd2, v); check("R4 disabled channel ignores edges", v, 16'h0);
      check("R4 no wake", {15'h0, wake}, 16'h0);
      tidy();
   endtask

   task automatic t_route();
      wr(3'd0, 16'hC208);
      wr(3'd4, 16'h0080);          // ch3 -> irq2
      wr(3'd5, 16'hF004);          // ch9 -> irq1, ch14/ch15 -> irq3
      drive(16'h0200);
      check("R6 ch9 to irq1", {12'h0, irq}, 16'h2);
      check("R9 wake on ch9", {15'h0, wake}, 16'h1);
      drive(16'h4200);
      check("R6 ch14 to irq3", {12'h0, irq}, 16'hA);
      wr(3'd2, 16'h0200);
      check("R6 clear ch9", {12'h0, irq}, 16'h8);
      drive(16'h4208);
      check("R6 ch3 to irq2", {12'h0, irq}, 16'hC);
      wr(3'd2, 16'hFFFF);
      check("R9 wake low when nothing pending", {15'h0, wake}, 16'h0);
      drive(16'hC208);
      check("R6 ch15 to irq3", {12'h0, irq}, 16'h8);
      wr(3'd5, 16'h3004);          // move ch15 to irq0
      check("R6 reroute without edge", {12'h0, irq}, 16'h1);
      check("R9 wake independent of route", {15'h0, wake}, 16'h1);
      tidy();
   endtask

   task automatic t_disable_keep();
      logic [15:0] v;
      wr(3'd0, 16'h0020);
      drive(16'h0020);
      check("R10 irq while enabled", {12'h0, irq}, 16'h1);
      wr(3'd0, 16'h0000);
      rd(3'd2, v); check("R10 pending kept after disable", v, 16'h0020);
      check("R10 irq dropped", {12'h0, irq}, 16'h0);
      check("R10 wake dropped", {15'h0, wake}, 16'h0);
      wr(3'd0, 16'h0020);
      check("R10 irq restored", {12'h0, irq}, 16'h1);
      check("R10 wake restored", {15'h0, wake}, 16'h1);
      tidy();
   endtask

   task automatic t_edge_wins();
      logic [15:0] v;
      wr(3'd0, 16'h00C0);
      drive(16'h0080);             // ch7 pending beforehand
      @(negedge clk); ch_in = 16'h00C0;
      repeat (2) @(posedge clk);
      @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 16'h00C0;
      @(posedge clk);
      @(negedge clk); wr_en = 1'b0;
      rd(3'd2, v); check("R8 edge beats same-cycle clear", v, 16'h0040);
      tidy();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_rise();
      t_fall();
      t_disabled();
      t_route();
      t_disable_keep();
      t_edge_wins();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule